// File: doc/BRIEF.md
# Register Exchange Sequencer

This block exchanges the values held in two N-bit storage registers by moving data over one shared internal bus in three transfers, using a third register as scratch space. A pulse or level on `start` begins a swap. The controller then steps through three transfer cycles on its own. In each of these cycles it picks exactly one register to drive the bus and one register to capture it. `done` is high during the last transfer.

The bus is a multiplexer selected by one-hot drive enables, so it needs no tri-state logic. The only other way to write the registers is a per-register preload port. The bench uses it to set up operands, and it has priority over a bus capture that targets the same register in the same cycle. The drive and load enables, the bus value and all three registers are brought out to the ports so they can be observed.

Top module: `swap_unit`

## Requirements
- R1: A synchronous active-high `rst` returns the controller to idle and clears all three registers. After reset, `done`, `bus_drive`, `bus_load` and `bus_data` are all 0.
- R2: While idle with `start` low, the controller stays idle. All drive and load enables are 0 and the register values do not change.
- R3: On the clock edge where the controller is idle and `start` is 1, it enters the stash cycle. In the stash cycle `bus_drive`=3'b010 (bit 0 = reg1, bit 1 = reg2, bit 2 = reg3), `bus_load`=3'b100 and `bus_data` equals reg2. At the end of that cycle reg3 takes the bus value.
- R4: The move cycle follows the stash cycle. It has `bus_drive`=3'b001 and `bus_load`=3'b010, so reg2 captures reg1.
- R5: The restore cycle follows the move cycle. It has `bus_drive`=3'b100, `bus_load`=3'b001 and `done`=1. Once the controller is back in idle, reg1 and reg2 hold each other's former values and reg3 holds the former reg2.
- R6: The stash, move and restore cycles each advance on the next clock whatever the value of `start`.
- R7: At most one drive enable and at most one load enable are high in any cycle. Both are all-zero when idle. `bus_data` is the value of the one driving register, or 0 when none drives.
- R8: If `start` is still 1 when the controller returns to idle, the next swap begins after exactly one idle cycle. A held `start` therefore gives `done` once every four cycles.
- R9: A set bit of `preload_we` writes `preload_data` into that register at the clock edge. It takes priority over a bus capture into the same register in the same cycle.
- R10: `done` is high for exactly one cycle per swap and never in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a swap when sampled in idle |
| preload_we | input | 3 | Per-register write enables for preload (bit 0 reg1, bit 1 reg2, bit 2 reg3) |
| preload_data | input | W | Preload value |
| bus_drive | output | 3 | One-hot bus drive enables |
| bus_load | output | 3 | Bus capture enables |
| bus_data | output | W | Shared bus value |
| done | output | 1 | High during the final transfer |
| reg1_q | output | W | reg1 contents |
| reg2_q | output | W | reg2 contents |
| reg3_q | output | W | reg3 contents (scratch) |

## Verification
Two events can fall in the same cycle. One is a preload write that hits the register the bus is capturing into. The bench provokes this by preloading reg2 during the move cycle, and expects reg2 to end with the preload value while the other transfers of the swap still happen. The other is the end of one swap meeting the start of the next. The bench holds `start` high across several swaps and judges the spacing of `done` cycle by cycle and the register contents after an odd number of exchanges. Every operand pair of a 4-bit configuration is also swapped, with noise on `start` during the busy cycles.

// File: rtl/swap_pkg.sv
package swap_pkg;

    localparam int NREG = 3;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_STASH   = 2'd1,
        ST_MOVE    = 2'd2,
        ST_RESTORE = 2'd3
    } swap_state_e;

    typedef struct packed {
        logic [NREG-1:0] drive;
        logic [NREG-1:0] load;
        logic            done;
    } swap_ctrl_t;

    // bit 0 = reg1, bit 1 = reg2, bit 2 = reg3
    function automatic swap_ctrl_t decode_state(swap_state_e s);
        swap_ctrl_t c;
        c = '0;
        case (s)
            ST_STASH:   begin c.drive = 3'b010; c.load = 3'b100; end
            ST_MOVE:    begin c.drive = 3'b001; c.load = 3'b010; end
            ST_RESTORE: begin c.drive = 3'b100; c.load = 3'b001; c.done = 1'b1; end
            default:    c = '0;
        endcase
        return c;
    endfunction

    function automatic swap_state_e next_state(swap_state_e s, logic go);
        case (s)
            ST_IDLE:    return go ? ST_STASH : ST_IDLE;
            ST_STASH:   return ST_MOVE;
            ST_MOVE:    return ST_RESTORE;
            default:    return ST_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/swap_fsm.sv
module swap_fsm
    import swap_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    output swap_ctrl_t ctrl
);

    swap_state_e state_q;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= next_state(state_q, start);
    end

    assign ctrl = decode_state(state_q);

    // R6
    stash_adv_chk: assert property (@(posedge clk) disable iff (rst)
        state_q == ST_STASH |=> state_q == ST_MOVE);
    // R6
    move_adv_chk: assert property (@(posedge clk) disable iff (rst)
        state_q == ST_MOVE |=> state_q == ST_RESTORE);
    // R8
    restore_adv_chk: assert property (@(posedge clk) disable iff (rst)
        state_q == ST_RESTORE |=> state_q == ST_IDLE);
    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && !start) |=> ctrl.drive == '0 && ctrl.load == '0);
    // R7
    one_driver_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ctrl.drive) && $countones(ctrl.load) <= 1);
    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl.done |=> !ctrl.done);

endmodule

// File: rtl/swap_datapath.sv
module swap_datapath
    import swap_pkg::*;
#(
    parameter int W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NREG-1:0] drive,
    input  logic [NREG-1:0] load,
    input  logic [NREG-1:0] pre_we,
    input  logic [W-1:0]    pre_data,
    output logic [W-1:0]    q [NREG],
    output logic [W-1:0]    bus
);

    logic [W-1:0] regs [NREG];

    always_comb begin
        bus = '0;
        for (int i = 0; i < NREG; i++)
            bus = bus | (regs[i] & {W{drive[i]}});
    end

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)            regs[g] <= '0;
            else if (pre_we[g]) regs[g] <= pre_data;
            else if (load[g])   regs[g] <= bus;
        end
        assign q[g] = regs[g];

        // R3
        capture_chk: assert property (@(posedge clk) disable iff (rst)
            (load[g] && !pre_we[g]) |=> regs[g] == $past(bus));
        // R9
        preload_chk: assert property (@(posedge clk) disable iff (rst)
            pre_we[g] |=> regs[g] == $past(pre_data));
        // R2
        hold_chk: assert property (@(posedge clk) disable iff (rst)
            (!load[g] && !pre_we[g]) |=> $stable(regs[g]));
    end

endmodule

// File: rtl/swap_unit.sv
module swap_unit
    import swap_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [2:0]   preload_we,
    input  logic [W-1:0] preload_data,
    output logic [2:0]   bus_drive,
    output logic [2:0]   bus_load,
    output logic [W-1:0] bus_data,
    output logic         done,
    output logic [W-1:0] reg1_q,
    output logic [W-1:0] reg2_q,
    output logic [W-1:0] reg3_q
);

    swap_ctrl_t   ctrl;
    logic [W-1:0] q [NREG];

    swap_fsm u_fsm (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .ctrl  (ctrl)
    );

    swap_datapath #(.W(W)) u_dp (
        .clk      (clk),
        .rst      (rst),
        .drive    (ctrl.drive),
        .load     (ctrl.load),
        .pre_we   (preload_we),
        .pre_data (preload_data),
        .q        (q),
        .bus      (bus_data)
    );

    assign bus_drive = ctrl.drive;
    assign bus_load  = ctrl.load;
    assign done      = ctrl.done;
    assign reg1_q    = q[0];
    assign reg2_q    = q[1];
    assign reg3_q    = q[2];

    // R5
    done_restore_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> bus_drive == 3'b100 && bus_load == 3'b001);
    // R7
    idle_bus_chk: assert property (@(posedge clk) disable iff (rst)
        bus_drive == 3'b000 |-> bus_data == '0);

endmodule

// File: tb/swap_unit_bench.sv
module swap_unit_bench;

    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [2:0]   preload_we = '0;
    logic [W-1:0] preload_data = '0;
    logic [2:0]   bus_drive, bus_load;
    logic [W-1:0] bus_data, reg1_q, reg2_q, reg3_q;
    logic         done;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    swap_unit #(.W(W)) u_swap_unit (
        .clk(clk), .rst(rst), .start(start),
        .preload_we(preload_we), .preload_data(preload_data),
        .bus_drive(bus_drive), .bus_load(bus_load), .bus_data(bus_data),
        .done(done), .reg1_q(reg1_q), .reg2_q(reg2_q), .reg3_q(reg3_q)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            fails++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < 50000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic preload(input int idx, input logic [W-1:0] d);
        preload_we   = 3'b001 << idx;
        preload_data = d;
        tick;
        preload_we   = '0;
    endtask

    task automatic run_swap(input logic [W-1:0] a, input logic [W-1:0] b,
                            input logic [W-1:0] c, input logic noise);
        preload(0, a);
        preload(1, b);
        preload(2, c);
        start = 1'b1;
        tick;                               // stash cycle
        chk("R3 drive", {29'd0, bus_drive}, 32'b010);
        chk("R3 load",  {29'd0, bus_load},  32'b100);
        chk("R3 bus",   {28'd0, bus_data},  {28'd0, b});
        chk("R10 done stash", {31'd0, done}, 32'd0);
        start = noise;
        tick;                               // move cycle
        chk("R3 reg3 captured", {28'd0, reg3_q}, {28'd0, b});
        chk("R4 drive", {29'd0, bus_drive}, 32'b001);
        chk("R4 load",  {29'd0, bus_load},  32'b010);
        chk("R4 bus",   {28'd0, bus_data},  {28'd0, a});
        chk("R6 no done in move", {31'd0, done}, 32'd0);
        start = ~noise;
        tick;                               // restore cycle
        chk("R4 reg2 captured", {28'd0, reg2_q}, {28'd0, a});
        chk("R5 done", {31'd0, done}, 32'd1);
        chk("R5 drive", {29'd0, bus_drive}, 32'b100);
        chk("R5 load",  {29'd0, bus_load},  32'b001);
        chk("R5 bus",   {28'd0, bus_data},  {28'd0, b});
        start = 1'b0;
        tick;                               // idle
        chk("R5 reg1", {28'd0, reg1_q}, {28'd0, b});
        chk("R5 reg2", {28'd0, reg2_q}, {28'd0, a});
        chk("R5 reg3", {28'd0, reg3_q}, {28'd0, b});
        chk("R10 done cleared", {31'd0, done}, 32'd0);
        chk("R7 idle enables", {26'd0, bus_drive, bus_load}, 32'd0);
        tick;
        chk("R2 idle hold", {20'd0, reg1_q, reg2_q, reg3_q}, {20'd0, b, a, b});
        chk("R2 idle enables", {26'd0, bus_drive, bus_load}, 32'd0);
    endtask

    initial begin
        @(negedge clk);
        tick;
        tick;
        rst = 1'b0;
        // R1 reset state
        chk("R1 regs", {20'd0, reg1_q, reg2_q, reg3_q}, 32'd0);
        chk("R1 enables", {26'd0, bus_drive, bus_load}, 32'd0);
        chk("R1 done", {31'd0, done}, 32'd0);
        chk("R1 bus", {28'd0, bus_data}, 32'd0);
        tick;
        chk("R2 idle no start", {26'd0, bus_drive, bus_load}, 32'd0);

        // R3 R4 R5 R6: every operand pair
        for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++)
                run_swap(a[W-1:0], b[W-1:0], W'(a ^ b ^ 4'hA), a[0] ^ b[1]);

        // R9: preload collides with bus capture into reg2
        preload(0, 4'h3);
        preload(1, 4'h5);
        preload(2, 4'h0);
        start = 1'b1;
        tick;                               // stash
        start = 1'b0;
        tick;                               // move: reg2 capture
        preload_we = 3'b010;
        preload_data = 4'h9;
        tick;                               // restore
        preload_we = '0;
        chk("R9 preload wins", {28'd0, reg2_q}, 32'h9);
        chk("R9 reg3 untouched", {28'd0, reg3_q}, 32'h5);
        tick;
        chk("R9 reg1 restored", {28'd0, reg1_q}, 32'h5);

        // R8: held start gives back-to-back swaps
        preload(0, 4'h1);
        preload(1, 4'h2);
        start = 1'b1;
        for (int k = 1; k <= 12; k++) begin
            tick;
            chk("R8 done spacing", {31'd0, done}, {31'd0, (k % 4) == 3});
            if ((k % 4) == 0)
                chk("R8 idle gap", {29'd0, bus_drive}, 32'd0);
        end
        start = 1'b0;
        tick;
        chk("R8 three swaps reg1", {28'd0, reg1_q}, 32'h2);
        chk("R8 three swaps reg2", {28'd0, reg2_q}, 32'h1);

        // R1: reset in the middle of a swap
        preload(0, 4'h7);
        start = 1'b1;
        tick;
        start = 1'b0;
        tick;
        rst = 1'b1;
        tick;
        rst = 1'b0;
        chk("R1 mid-swap regs", {20'd0, reg1_q, reg2_q, reg3_q}, 32'd0);
        chk("R1 mid-swap enables", {26'd0, bus_drive, bus_load}, 32'd0);
        tick;
        chk("R1 stays idle", {31'd0, done}, 32'd0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule